// File: doc/BRIEF.md
# Auto-Increment Word Programmer for a Serial NOR Flash Slave

This block is the command and programming engine inside a serial NOR flash slave. A byte-level front end (SPI mode 0, already deserialised) hands it one received byte per valid strobe while the active-low chip select is held low. The engine decodes a small command set: set the write latch, clear the write latch, read status, and a streaming program command. It owns a small byte array that follows NOR rules. A program can only clear bits, and the erased value is 0xFF.

Streaming programming is a sequence of several frames. The first program frame carries a big-endian address, and the engine clears bit 0 of that address before the first data byte. Each later program frame carries data only and continues from where the last one stopped. Each data byte goes to the current address, and the address then steps up by one. When the step carries the address past the top of the array, the sequence ends by itself: the write latch and the streaming flag both drop, and programming does not wrap around.

A side port reads any array location combinationally, so the surrounding logic or a bench can observe the stored contents.

Top module: `spi_aai_prog`

## Requirements
- R1: After reset the write latch and the streaming flag are 0, every array byte reads 0xFF, `tx_byte_o` is 0xFF and all three pulse outputs are low.
- R2: Opcode 0x06 as the first byte of a frame sets the write latch (`wel_o`).
- R3: Opcode 0xAD with the write latch clear raises `prot_err_o` for one cycle, leaves the streaming flag at 0, and the rest of that frame changes no array byte.
- R4: The first 0xAD with the latch set and the flag clear sets the flag and then takes three address bytes, most significant first. Only the low ADDR_W bits are used, and bit 0 is forced to 0, so an odd address starts at the even address just below it.
- R5: A 0xAD while the flag is set takes no address bytes. Its data bytes continue at the address that follows the last programmed byte, including across chip-select deassertion.
- R6: Each data byte in a program frame with the latch set stores old AND new at the current address, and the address then steps by one modulo 2^ADDR_W.
- R7: When that step takes the address from 2^ADDR_W-1 to 0 while the flag is set, the byte at the top address is still stored, and the latch and the flag both read 0 from the next cycle on.
- R8: Opcode 0x04 clears the write latch and the streaming flag.
- R9: After opcode 0x05 and after each further byte of the same frame, `tx_byte_o` holds the status byte: bit 6 is the streaming flag, bit 1 is the write latch, and all other bits are 0. Outside such a frame it holds 0xFF.
- R10: While the flag is set, any opcode other than 0xAD, 0x04 and 0x05 raises `illegal_cmd_o` for one cycle, and 0x06 still sets the latch. While the flag is clear, no opcode raises it.
- R11: Data bytes that arrive in a program frame after the write latch has cleared leave the array unchanged and raise no warning.
- R12: A stored data byte that has a 1 where the array holds a 0 raises `set_warn_o` for one cycle, and the stored value stays old AND new.
- R13: Chip select going high ends the frame and returns the decoder to opcode decode, but it keeps the streaming flag, the latch and the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; high ends the frame |
| rx_valid_i | input | 1 | One received byte is present this cycle |
| rx_byte_i | input | 8 | Received byte |
| tx_byte_o | output | 8 | Byte to shift out on the next transfer (status or 0xFF) |
| wel_o | output | 1 | Write latch |
| aai_o | output | 1 | Streaming-program flag |
| prot_err_o | output | 1 | Pulse: program command refused because the latch is clear |
| illegal_cmd_o | output | 1 | Pulse: disallowed opcode while streaming |
| set_warn_o | output | 1 | Pulse: a program byte tried to set a cleared bit |
| peek_addr_i | input | ADDR_W | Array read address |
| peek_data_o | output | 8 | Array byte at `peek_addr_i` |

## Verification
The delicate cycle is the data byte that lands on the top address. In that single edge the array must store the byte, the set-bit warning must be judged against the old contents, and the write latch and streaming flag must both drop. The bench provokes this edge by streaming from several start addresses, odd and even, up to the wrap. After every byte it compares the warning, the latch and the flag against a bench-side model. It then sends more bytes in the same frame and checks that the array stays as it was. A second coincidence is an illegal opcode that is also executed: 0x06 during streaming must both pulse the error and leave the latch set.

// File: rtl/spi_aai_pkg.sv
package spi_aai_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_AAI  = 8'hAD;
  localparam logic [7:0] TX_IDLE = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PROG,
    ST_STAT,
    ST_SKIP
  } eng_state_e;

  function automatic logic [7:0] pack_status(input logic wel, input logic aai);
    return {1'b0, aai, 4'b0000, wel, 1'b0};
  endfunction
endpackage

// File: rtl/aai_nor_array.sv
module aai_nor_array #(
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              set_warn_o
);
  logic [7:0] mem_q [DEPTH];
  logic [7:0] old_byte;

  assign old_byte  = mem_q[wr_addr_i];
  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      set_warn_o <= 1'b0;
    end else begin
      set_warn_o <= wr_en_i && |(wr_data_i & ~old_byte);
      if (wr_en_i) mem_q[wr_addr_i] <= old_byte & wr_data_i;
    end
  end

  // R12: a write that tries to raise a cleared bit is flagged next cycle
  p_set_warn_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && |(wr_data_i & ~old_byte)) |=> set_warn_o);
  // R11: no warning without a write
  p_warn_needs_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !set_warn_o);
endmodule

// File: rtl/aai_cmd_engine.sv
module aai_cmd_engine
  import spi_aai_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int ADDR_BYTES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [7:0]        tx_byte_o,
  output logic              wel_o,
  output logic              aai_o,
  output logic              prot_err_o,
  output logic              illegal_cmd_o
);
  localparam int SHIFT_W = 8 * ADDR_BYTES;
  localparam int CNT_W   = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

  eng_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SHIFT_W-1:0]  shift_q, shift_nxt;
  logic [ADDR_W-1:0]   addr_q, addr_inc;
  logic                wel_q, aai_q, fire, cmd_ok_aai;

  assign fire       = rx_valid_i && !cs_ni;
  assign shift_nxt  = (shift_q << 8) | SHIFT_W'(rx_byte_i);
  assign addr_inc   = addr_q + 1'b1;
  assign cmd_ok_aai = (rx_byte_i == OP_AAI) || (rx_byte_i == OP_WRDI) || (rx_byte_i == OP_RDSR);

  assign wr_en_o   = fire && (state_q == ST_PROG) && wel_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = rx_byte_i;
  assign wel_o     = wel_q;
  assign aai_o     = aai_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      shift_q       <= '0;
      addr_q        <= '0;
      wel_q         <= 1'b0;
      aai_q         <= 1'b0;
      tx_byte_o     <= TX_IDLE;
      prot_err_o    <= 1'b0;
      illegal_cmd_o <= 1'b0;
    end else begin
      prot_err_o    <= 1'b0;
      illegal_cmd_o <= 1'b0;
      if (cs_ni) begin
        state_q   <= ST_IDLE;
        tx_byte_o <= TX_IDLE;
      end else if (rx_valid_i) begin
        tx_byte_o <= TX_IDLE;
        unique case (state_q)
          ST_IDLE: begin
            if (aai_q && !cmd_ok_aai) illegal_cmd_o <= 1'b1;
            state_q <= ST_SKIP;
            case (rx_byte_i)
              OP_WREN: wel_q <= 1'b1;
              OP_WRDI: begin
                wel_q <= 1'b0;
                aai_q <= 1'b0;
              end
              OP_RDSR: begin
                state_q   <= ST_STAT;
                tx_byte_o <= pack_status(wel_q, aai_q);
              end
              OP_AAI: begin
                if (!wel_q) begin
                  prot_err_o <= 1'b1;
                end else if (aai_q) begin
                  state_q <= ST_PROG;
                end else begin
                  aai_q   <= 1'b1;
                  cnt_q   <= '0;
                  shift_q <= '0;
                  state_q <= ST_ADDR;
                end
              end
              default: ;
            endcase
          end
          ST_ADDR: begin
            shift_q <= shift_nxt;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              addr_q  <= {shift_nxt[ADDR_W-1:1], 1'b0};
              state_q <= ST_PROG;
            end
          end
          ST_PROG: begin
            addr_q <= addr_inc;
            if (aai_q && (addr_inc == '0)) begin
              wel_q <= 1'b0;
              aai_q <= 1'b0;
            end
          end
          ST_STAT: tx_byte_o <= pack_status(wel_q, aai_q);
          default: ;
        endcase
      end
    end
  end

  // R7: streaming never runs without the write latch
  p_aai_needs_wel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aai_q |-> wel_q);
  // R4: collected start address is even
  p_even_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && state_q == ST_ADDR && cnt_q == CNT_LAST) |=> !addr_q[0]);
  // R7: stepping past the top ends the sequence
  p_wrap_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && state_q == ST_PROG && aai_q && addr_q == ADDR_TOP) |=> (!wel_q && !aai_q));
  // R3: refused program command
  p_prot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && state_q == ST_IDLE && rx_byte_i == OP_AAI && !wel_q) |=> (prot_err_o && !aai_q));
  // R10: illegal pulse only while streaming
  p_illegal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_cmd_o |-> $past(aai_q));
  // R13: chip select high keeps flag and address
  p_cs_keep_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> ($stable(aai_q) && $stable(addr_q) && state_q == ST_IDLE));
endmodule

// File: rtl/spi_aai_prog.sv
module spi_aai_prog #(
  parameter int ADDR_W     = 6,
  parameter int ADDR_BYTES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic [7:0]        tx_byte_o,
  output logic              wel_o,
  output logic              aai_o,
  output logic              prot_err_o,
  output logic              illegal_cmd_o,
  output logic              set_warn_o,
  input  logic [ADDR_W-1:0] peek_addr_i,
  output logic [7:0]        peek_data_o
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;

  aai_cmd_engine #(.ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES)) u_engine (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cs_ni         (cs_ni),
    .rx_valid_i    (rx_valid_i),
    .rx_byte_i     (rx_byte_i),
    .wr_en_o       (wr_en),
    .wr_addr_o     (wr_addr),
    .wr_data_o     (wr_data),
    .tx_byte_o     (tx_byte_o),
    .wel_o         (wel_o),
    .aai_o         (aai_o),
    .prot_err_o    (prot_err_o),
    .illegal_cmd_o (illegal_cmd_o)
  );

  aai_nor_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (peek_addr_i),
    .rd_data_o  (peek_data_o),
    .set_warn_o (set_warn_o)
  );
endmodule

// File: tb/spi_aai_prog_tb.sv
module spi_aai_prog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00, tx_byte, peek_data;
  logic wel, aai, prot_err, illegal, warn;
  logic [ADDR_W-1:0] peek_addr = '0;

  int checks = 0, failures = 0;
  logic [7:0] model [DEPTH];
  logic [ADDR_W-1:0] m_addr = '0;
  logic m_wel = 1'b0, m_aai = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_aai_prog #(.ADDR_W(ADDR_W), .ADDR_BYTES(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rx_valid_i(rx_valid),
    .rx_byte_i(rx_byte), .tx_byte_o(tx_byte), .wel_o(wel), .aai_o(aai),
    .prot_err_o(prot_err), .illegal_cmd_o(illegal), .set_warn_o(warn),
    .peek_addr_i(peek_addr), .peek_data_o(peek_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic cs_high();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    cs_low(); send(op); cs_high();
  endtask

  task automatic check_mem(input string req);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      peek_addr = ADDR_W'(i);
      #1;
      if (peek_data !== model[i]) bad++;
    end
    check(req, bad, 0);
  endtask

  // program one byte and compare warn, latch and flag with the model
  task automatic prog(input logic [7:0] d, input string req);
    logic exp_warn;
    exp_warn = m_wel && |(d & ~model[m_addr]);
    if (m_wel) model[m_addr] = model[m_addr] & d;
    send(d);
    m_addr = m_addr + 1'b1;
    if (m_aai && m_addr == '0) begin
      m_wel = 1'b0;
      m_aai = 1'b0;
    end
    check({req, " warn"}, warn, exp_warn);
    check({req, " wel"}, wel, m_wel);
    check({req, " aai"}, aai, m_aai);
  endtask

  task automatic start_aai(input logic [7:0] a);
    send(8'hAD); send(8'h00); send(8'h00); send(a);
    m_aai  = 1'b1;
    m_addr = ADDR_W'(a) & ~ADDR_W'(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 wel", wel, 0);
    check("R1 aai", aai, 0);
    check("R1 tx", tx_byte, 8'hFF);
    check("R1 pulses", {prot_err, illegal, warn}, 0);
    check_mem("R1 mem");
    // R9 status at reset, repeated
    cs_low(); send(8'h05); check("R9 status0", tx_byte, 8'h00);
    send(8'h00); check("R9 repeat0", tx_byte, 8'h00);
    cs_high(); check("R9 idle tx", tx_byte, 8'hFF);
    // R3 refused program
    cs_low(); send(8'hAD); check("R3 prot", prot_err, 1);
    check("R3 aai", aai, 0);
    send(8'h00); check("R3 pulse width", prot_err, 0);
    send(8'h00); send(8'h02); send(8'h00); send(8'h00);
    cs_high(); check_mem("R3 mem");
    // R2
    cmd1(8'h06); m_wel = 1'b1;
    check("R2 wel", wel, 1);
    cs_low(); send(8'h05); check("R9 wel bit", tx_byte, 8'h02); cs_high();
    // R4 odd address 5 -> start 4, R6
    cs_low(); start_aai(8'h05);
    check("R4 aai", aai, 1);
    prog(8'hA5, "R6 b0"); prog(8'h3C, "R6 b1");
    cs_high(); check_mem("R4 R6 mem");
    check("R13 aai kept", aai, 1);
    // R9 streaming status
    cs_low(); send(8'h05); check("R9 status", tx_byte, 8'h42);
    check("R10 rdsr legal", illegal, 0);
    send(8'h00); check("R9 rep1", tx_byte, 8'h42);
    send(8'h00); check("R9 rep2", tx_byte, 8'h42);
    cs_high();
    // R10 illegal while streaming
    cmd1(8'h06);
    check("R10 wren illegal", illegal, 0);
    cs_low(); send(8'h06); check("R10 wren pulse", illegal, 1); cs_high();
    check("R10 wren executed", wel, 1);
    cs_low(); send(8'h9F); check("R10 9F pulse", illegal, 1);
    send(8'h00); send(8'h00); cs_high();
    check_mem("R10 mem");
    // R5 continuation from address 6
    cs_low(); send(8'hAD); check("R5 no prot", prot_err, 0);
    prog(8'h0F, "R5 b0"); prog(8'h80, "R5 b1");
    cs_high(); check_mem("R5 mem");
    // R8
    cs_low(); send(8'h04); check("R10 wrdi legal", illegal, 0); cs_high();
    m_wel = 1'b0; m_aai = 1'b0;
    check("R8 wel", wel, 0);
    check("R8 aai", aai, 0);
    cmd1(8'h20); check("R10 inactive", illegal, 0);
    // R12 set-bit warning over programmed bytes
    cmd1(8'h06); m_wel = 1'b1;
    cs_low(); start_aai(8'h04);
    prog(8'hFF, "R12 set"); prog(8'h3C, "R12 same");
    cs_high(); check_mem("R12 mem");
    cmd1(8'h04); m_wel = 1'b0; m_aai = 1'b0;
    // R7 R11 sweep of start addresses up to the wrap
    for (int s = 0; s < DEPTH; s += 7) begin
      cmd1(8'h06); m_wel = 1'b1;
      cs_low(); start_aai(8'(s));
      for (int k = 0; m_aai; k++) prog(8'((s * 13 + k * 29) ^ 8'h5A), "R7 stream");
      prog(8'h00, "R11 after abort"); prog(8'h00, "R11 after abort");
      cs_high();
      check_mem("R7 R11 mem");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule